// File: doc/BRIEF.md
# Two-Wire Serial Data Memory Slave

This block is a small on-chip data memory of sixteen bytes that answers on a two-wire serial bus: a clock line driven by the master and a shared data line that every party can only pull low, while a weak pull-up makes a released line read as 1. The block samples both lines with the system clock and recognises the bus START and STOP conditions. It decodes the control byte (a 7-bit device code plus a read/write flag) and then carries out one of three operations: writing one byte, reading at the address held in its internal pointer, or reading at an address the master supplies first.

A byte write is not stored as it arrives. It is committed when the STOP condition is seen. From that point a self-timed write cycle runs for a parameter number of system clocks, and while it runs the block refuses every control byte, so the master sees no acknowledge and has to retry. A random read is a write of the address only, followed by a repeated START and a read control byte. An address-only write therefore moves the pointer without touching the array and without starting a write cycle.

Top module: `twi_mem16`

## Requirements
- R1: After reset the data line is released (`sda_pull_o` = 0), every memory byte reads 0x00, the internal pointer is 0 and the block is not busy.
- R2: A falling data line while the clock is high (START) begins reception of a control byte, sent MSB first. The device code is the upper seven bits (0x50) and bit 0 is the direction, where 1 means read. A matching control byte is acknowledged by pulling the data line low for the whole ninth clock. A rising data line while the clock is high (STOP) releases the line.
- R3: A control byte with a different device code is not acknowledged, and every further byte up to the next START or STOP is ignored and not acknowledged. Memory is not changed.
- R4: Byte write is control 0xA0, an address byte and a data byte, each acknowledged. Only the low four bits of the address byte are used. The data byte is written at STOP and the pointer then points to the next address.
- R5: For `WR_CYCLES` system clocks after a write STOP, control bytes are not acknowledged. After that window they are acknowledged again.
- R6: Control 0xA1 returns the byte at the pointer, MSB first, and the pointer advances after each byte sent. The pointer wraps from 15 to 0.
- R7: Random read (control 0xA0, address, repeated START, control 0xA1) returns the byte at the supplied address. An address-only write followed by STOP changes no memory byte and starts no busy window.
- R8: When the master acknowledges a read byte, the next byte follows. When it does not, the slave leaves the line released until the next START or STOP.
- R9: A second data byte within one write transaction is not acknowledged, and only the first data byte is written.
- R10: `sda_pull_o` changes only while the clock line is low, except right after a START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Serial clock line from the master |
| sda_i | input | 1 | Level of the shared data line |
| sda_pull_o | output | 1 | When 1, the block pulls the data line low |

## Verification
The bus lines pass through a two-stage synchronizer and an edge register, and the output is registered. Every response of the slave therefore appears about three system clocks after the bus clock edge that causes it: an acknowledge or a read bit after a falling clock, and a stored byte or a busy window after STOP. The bench holds each half bus period for ten system clocks, and it reads acknowledges and read bits in the middle of the clock-high phase, well after that three-clock latency and well before the next falling edge. The busy window is checked with a control byte sent a few clocks after the write STOP, which ends far inside `WR_CYCLES`. Each retry is sent only after waiting `WR_CYCLES` plus a margin.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CTRL,
    ST_CTRL_ACK,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_TX,
    ST_RACK,
    ST_WAIT
  } twi_state_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_pipe;
  logic [SYNC_STAGES-1:0] sda_pipe;
  logic scl_q;
  logic sda_q;
  logic scl_now;

  // Idle bus level is high on both lines.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[SYNC_STAGES-1];
      sda_q    <= sda_pipe[SYNC_STAGES-1];
    end
  end

  assign scl_now   = scl_pipe[SYNC_STAGES-1];
  assign sda_s     = sda_pipe[SYNC_STAGES-1];
  assign scl_rise  = scl_now & ~scl_q;
  assign scl_fall  = ~scl_now & scl_q;
  assign start_det = scl_now & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_now & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/twi_busy_timer.sv
module twi_busy_timer #(
  parameter int WR_CYCLES = 400000,
  parameter int CNT_W     = $clog2(WR_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = CNT_W'(WR_CYCLES);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/twi_mem_array.sv
module twi_mem_array #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] word_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic hit;
    assign hit = we && (waddr == ADDR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[g] <= '0;
      end else if (hit) begin
        word_q[g] <= wdata;
      end
    end
  end

  assign rdata = word_q[raddr];
endmodule

// File: rtl/twi_mem16.sv
module twi_mem16
  import twi_mem_pkg::*;
#(
  parameter int              DEPTH       = 16,
  parameter int              DATA_W      = 8,
  parameter logic [DATA_W-2:0] DEV_ID    = 7'h50,
  parameter int              WR_CYCLES   = 400000,
  parameter int              SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull_o
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int BIT_W  = $clog2(DATA_W + 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign srst_n = rst_pipe[1];

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic busy, timer_load, mem_we, tx_load;
  logic [DATA_W-1:0] rdata;

  twi_state_e         state_q, state_d;
  logic [BIT_W-1:0]   cnt_q, cnt_d;
  logic [DATA_W-1:0]  sh_q, sh_d;
  logic [DATA_W-1:0]  wbuf_q, wbuf_d;
  logic [ADDR_W-1:0]  ptr_q, ptr_d;
  logic               wpend_q, wpend_d;
  logic               rw_q, rw_d;
  logic               mack_q, mack_d;
  logic               pull_q, pull_d;

  twi_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (srst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  twi_busy_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (srst_n),
    .load  (timer_load),
    .busy  (busy)
  );

  twi_mem_array #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk   (clk),
    .rst_n (srst_n),
    .we    (mem_we),
    .waddr (ptr_q),
    .wdata (wbuf_q),
    .raddr (ptr_q),
    .rdata (rdata)
  );

  // Next-state logic
  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    sh_d       = sh_q;
    wbuf_d     = wbuf_q;
    ptr_d      = ptr_q;
    wpend_d    = wpend_q;
    rw_d       = rw_q;
    mack_d     = mack_q;
    pull_d     = pull_q;
    mem_we     = 1'b0;
    timer_load = 1'b0;
    tx_load    = 1'b0;

    if (start_det) begin
      state_d = ST_CTRL;
      cnt_d   = '0;
      pull_d  = 1'b0;
      wpend_d = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      pull_d  = 1'b0;
      if (wpend_q) begin
        mem_we     = 1'b1;
        timer_load = 1'b1;
        ptr_d      = ptr_q + 1'b1;
        wpend_d    = 1'b0;
      end
    end else begin
      unique case (state_q)
        ST_CTRL, ST_ADDR, ST_WDATA: begin
          if (scl_rise && cnt_q != LAST_BIT) begin
            sh_d  = {sh_q[DATA_W-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end
          if (scl_fall && cnt_q == LAST_BIT) begin
            cnt_d = '0;
            if (state_q == ST_CTRL) begin
              if (sh_q[DATA_W-1:1] == DEV_ID && !busy) begin
                pull_d  = 1'b1;
                rw_d    = sh_q[0];
                state_d = ST_CTRL_ACK;
              end else begin
                state_d = ST_WAIT;
              end
            end else if (state_q == ST_ADDR) begin
              pull_d  = 1'b1;
              ptr_d   = sh_q[ADDR_W-1:0];
              state_d = ST_ADDR_ACK;
            end else begin
              pull_d  = 1'b1;
              wbuf_d  = sh_q;
              wpend_d = 1'b1;
              state_d = ST_WDATA_ACK;
            end
          end
        end
        ST_CTRL_ACK: begin
          if (scl_fall) begin
            pull_d = 1'b0;
            if (rw_q) begin
              tx_load = 1'b1;
            end else begin
              state_d = ST_ADDR;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            pull_d  = 1'b0;
            state_d = ST_WDATA;
          end
        end
        ST_WDATA_ACK: begin
          if (scl_fall) begin
            pull_d  = 1'b0;
            state_d = ST_WAIT;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == LAST_BIT) begin
              pull_d  = 1'b0;
              cnt_d   = '0;
              state_d = ST_RACK;
            end else begin
              sh_d   = {sh_q[DATA_W-2:0], 1'b0};
              pull_d = ~sh_q[DATA_W-2];
              cnt_d  = cnt_q + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
          end
          if (scl_fall) begin
            if (mack_q) begin
              tx_load = 1'b1;
            end else begin
              state_d = ST_WAIT;
            end
          end
        end
        default: begin
        end
      endcase

      if (tx_load) begin
        sh_d    = rdata;
        ptr_d   = ptr_q + 1'b1;
        pull_d  = ~rdata[DATA_W-1];
        cnt_d   = BIT_W'(1);
        state_d = ST_TX;
      end
    end
  end

  // State registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      wbuf_q  <= '0;
      ptr_q   <= '0;
      wpend_q <= 1'b0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      pull_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      wbuf_q  <= wbuf_d;
      ptr_q   <= ptr_d;
      wpend_q <= wpend_d;
      rw_q    <= rw_d;
      mack_q  <= mack_d;
      pull_q  <= pull_d;
    end
  end

  assign sda_pull_o = pull_q;
endmodule

// File: rtl/twi_mem16_chk.sv
module twi_mem16_chk
  import twi_mem_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_rise,
  input logic              scl_fall,
  input logic              start_det,
  input logic              stop_det,
  input twi_state_e        state,
  input logic              pull,
  input logic              busy,
  input logic              mem_we,
  input logic [ADDR_W-1:0] ptr
);
  logic scl_hi;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_hi <= 1'b1;
    end else if (scl_rise) begin
      scl_hi <= 1'b1;
    end else if (scl_fall) begin
      scl_hi <= 1'b0;
    end
  end

  AST_PULL_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_hi && $past(scl_hi) && !$past(start_det) && !$past(stop_det)) |-> $stable(pull)); // R10
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !pull); // R2
  AST_WAIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) |-> !pull); // R3
  AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CTRL && busy && !start_det && !stop_det) |=> (state != ST_CTRL_ACK)); // R5
  AST_WRITE_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> busy); // R5
  AST_PTR_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && ptr == ADDR_W'(DEPTH - 1)) |=> (ptr == '0)); // R6
endmodule

bind twi_mem16 twi_mem16_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (srst_n),
  .scl_rise  (scl_rise),
  .scl_fall  (scl_fall),
  .start_det (start_det),
  .stop_det  (stop_det),
  .state     (state_q),
  .pull      (pull_q),
  .busy      (busy),
  .mem_we    (mem_we),
  .ptr       (ptr_q)
);

// File: tb/sim_twi_mem16.sv
`timescale 1ns/1ps
module sim_twi_mem16;
  localparam int WRC = 400;
  localparam int H   = 10;

  logic clk, rst_n, scl, m_sda;
  logic sda_pull_o;
  logic sda_i;
  int   n_checks, n_errors;
  int   r10_viol;
  logic scl_prev, pull_prev;

  assign sda_i = m_sda & ~sda_pull_o;

  twi_mem16 #(.WR_CYCLES(WRC)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl),
    .sda_i      (sda_i),
    .sda_pull_o (sda_pull_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // R10 monitor: the pull must not move while the bus clock stays high.
  always @(negedge clk) begin
    if (rst_n && scl && scl_prev && (sda_pull_o != pull_prev)) r10_viol++;
    scl_prev  = scl;
    pull_prev = sda_pull_o;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic m_start();
    m_sda = 1'b1; tick(H);
    scl = 1'b1;   tick(H);
    m_sda = 1'b0; tick(H);
    scl = 1'b0;   tick(H);
  endtask

  task automatic m_stop();
    m_sda = 1'b0; tick(H);
    scl = 1'b1;   tick(H);
    m_sda = 1'b1; tick(H);
  endtask

  task automatic m_send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(H);
      scl = 1'b1;   tick(H);
      scl = 1'b0;   tick(2);
    end
    m_sda = 1'b1; tick(H);
    scl = 1'b1;   tick(H/2);
    ack = (sda_i == 1'b0);
    tick(H/2);
    scl = 1'b0;   tick(2);
  endtask

  task automatic m_recv(input logic give_ack, output logic [7:0] b);
    b = 8'h00;
    m_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(H);
      scl = 1'b1; tick(H/2);
      b = {b[6:0], sda_i};
      tick(H/2);
      scl = 1'b0; tick(2);
    end
    m_sda = give_ack ? 1'b0 : 1'b1; tick(H);
    scl = 1'b1; tick(H);
    scl = 1'b0; tick(2);
    m_sda = 1'b1;
  endtask

  task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
    logic ack;
    m_start();
    m_send(8'hA0, ack); check("R2 write control ack", ack, 1);
    m_send(a, ack);     check("R4 address ack", ack, 1);
    m_send(d, ack);     check("R4 data ack", ack, 1);
    m_stop();
    tick(WRC + 40);
  endtask

  task automatic rd_random(input logic [7:0] a, output logic [7:0] d);
    logic ack;
    m_start();
    m_send(8'hA0, ack); check("R7 dummy write ack", ack, 1);
    m_send(a, ack);     check("R7 address ack", ack, 1);
    m_start();
    m_send(8'hA1, ack); check("R7 read control ack", ack, 1);
    m_recv(1'b0, d);
    m_stop();
  endtask

  task automatic rd_current(output logic [7:0] d);
    logic ack;
    m_start();
    m_send(8'hA1, ack); check("R6 read control ack", ack, 1);
    m_recv(1'b0, d);
    m_stop();
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 pull released after reset", sda_pull_o, 0);
    rd_current(d);
    check("R1 byte at pointer 0 after reset", d, 8'h00);
    rd_random(8'h0B, d);
    check("R1 byte 11 after reset", d, 8'h00);
  endtask

  task automatic t_write_busy();
    logic ack;
    logic [7:0] d;
    m_start();
    m_send(8'hA0, ack); check("R2 control ack", ack, 1);
    m_send(8'h03, ack); check("R4 address ack", ack, 1);
    m_send(8'hA5, ack); check("R4 data ack", ack, 1);
    m_stop();
    tick(5);
    m_start();
    m_send(8'hA0, ack); check("R5 control refused while busy", ack, 0);
    m_stop();
    tick(WRC + 40);
    m_start();
    m_send(8'hA1, ack); check("R5 control accepted after window", ack, 1);
    m_recv(1'b0, d);
    check("R4 pointer moved past written address", d, 8'h00);
    m_stop();
  endtask

  task automatic t_reads();
    logic [7:0] d;
    wr_byte(8'h04, 8'h3C);
    wr_byte(8'h0F, 8'h81);
    wr_byte(8'hF0, 8'h7E);
    rd_random(8'h03, d); check("R7 random read addr 3", d, 8'hA5);
    rd_current(d);       check("R6 current read addr 4", d, 8'h3C);
    rd_random(8'h0F, d); check("R7 random read addr 15", d, 8'h81);
    rd_current(d);       check("R6 pointer wraps 15 to 0, R4 upper address bits ignored", d, 8'h7E);
  endtask

  task automatic t_sequential();
    logic ack;
    logic [7:0] d;
    m_start();
    m_send(8'hA0, ack);
    m_send(8'h03, ack);
    m_start();
    m_send(8'hA1, ack); check("R8 read control ack", ack, 1);
    m_recv(1'b1, d); check("R8 first byte", d, 8'hA5);
    m_recv(1'b1, d); check("R8 next byte after master ack", d, 8'h3C);
    m_recv(1'b0, d); check("R8 last byte", d, 8'h00);
    m_recv(1'b0, d); check("R8 line released after master nack", d, 8'hFF);
    m_stop();
  endtask

  task automatic t_wrong_id();
    logic ack;
    logic [7:0] d;
    m_start();
    m_send(8'hB0, ack); check("R3 foreign control not acked", ack, 0);
    m_send(8'h03, ack); check("R3 following byte not acked", ack, 0);
    m_send(8'h55, ack); check("R3 data byte not acked", ack, 0);
    m_stop();
    tick(5);
    rd_random(8'h03, d); check("R3 memory unchanged", d, 8'hA5);
  endtask

  task automatic t_two_data();
    logic ack;
    logic [7:0] d;
    m_start();
    m_send(8'hA0, ack);
    m_send(8'h06, ack);
    m_send(8'h11, ack); check("R9 first data ack", ack, 1);
    m_send(8'h22, ack); check("R9 second data refused", ack, 0);
    m_stop();
    tick(WRC + 40);
    rd_random(8'h06, d); check("R9 first byte stored", d, 8'h11);
    rd_current(d);       check("R9 second byte not stored", d, 8'h00);
  endtask

  task automatic t_addr_only();
    logic ack;
    logic [7:0] d;
    wr_byte(8'h09, 8'hC3);
    m_start();
    m_send(8'hA0, ack);
    m_send(8'h09, ack); check("R7 address-only ack", ack, 1);
    m_stop();
    tick(5);
    m_start();
    m_send(8'hA1, ack); check("R7 no busy window after address-only", ack, 1);
    m_recv(1'b0, d);    check("R7 pointer set, memory intact", d, 8'hC3);
    m_stop();
  endtask

  initial begin
    n_checks = 0; n_errors = 0; r10_viol = 0;
    scl_prev = 1'b1; pull_prev = 1'b0;
    scl = 1'b1; m_sda = 1'b1; rst_n = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_write_busy();
    t_reads();
    t_sequential();
    t_wrong_id();
    t_two_data();
    t_addr_only();
    check("R10 pull moved while clock high", r10_viol, 0);
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule